// File: doc/BRIEF.md
# Floating-Point Escape Opcode Decoder

This block sits in an instruction front end. It accepts instruction bytes one at a time, each qualified by a valid strobe. A first byte whose upper five bits are 11011 is one of the eight floating-point escape bytes. After such a byte, the decoder always takes the next valid byte as the ModR/M byte.

The ModR/M byte is read in one of two ways:
- **Memory form (below C0H):** bits 5..3 act as a three-bit extension that selects the operation within the group.
- **Register form (C0H and above):** the whole byte is the extension, and bits 2..0 name the stack register ST(i).

A memory form with mod 00 and r/m 101 is followed by a 32-bit displacement. The decoder assembles it little-endian: the first displacement byte received lands in bits 7..0.

The group with first byte D8H is decoded in full. The memory-form double-precision load of group DDH is also decoded. Every other combination reports its raw extension index. When the last byte of an instruction is accepted, a one-cycle completion pulse presents all decoded fields. The fields then hold until the next completion or a reset.

Top module: `fpu_esc_decoder`

## Requirements
- R1: After reset, `done` and `unsupported` are 0 and every decoded output is 0. An escape first byte (D8H..DFH) is accepted, and the next valid byte is always treated as the ModR/M byte. `grp_idx` reports bits 2..0 of the first byte.
- R2: A non-escape first byte (for example 90H, D7H, E0H) raises `unsupported` for exactly one cycle, the cycle after it is accepted, and does not raise `done`. The decoder keeps waiting for a first byte, so the following byte is again checked as a first byte.
- R3: Group D8H, memory form (ModR/M below C0H): `op_class` takes the extension value as follows: 0 add, 1 multiply, 2 compare, 3 compare-and-pop, 4 subtract, 5 reverse subtract, 6 divide, 7 reverse divide. `opnd_tag` is 1 (single-precision memory), `is_reg` is 0 and `ext_idx` is the extension value zero-extended.
- R4: Register form (ModR/M C0H or above), any group: `is_reg` is 1, `ext_idx` is the whole ModR/M byte and `st_idx` is ModR/M bits 2..0. For group D8H, `op_class` follows the R3 order using bits 5..3, and `opnd_tag` is 3 (stack register).
- R5: Group DDH, memory form, extension 000: `op_class` is 8 (load) and `opnd_tag` is 2 (double-precision memory).
- R6: Any other group/extension combination: `op_class` is 15 (raw) and `opnd_tag` is 0, with `ext_idx` as defined in R3/R4.
- R7: A ModR/M byte with mod 00 and r/m 101 is followed by four displacement bytes. They are assembled little-endian, first byte into `disp[7:0]`. The sequence DD 05 04 00 00 00 gives a load with `disp` = 00000004H.
- R8: Every other ModR/M byte ends the instruction and reports `disp` = 0.
- R9: `done` pulses for one cycle, in the cycle after the last byte of an instruction is accepted. The decoded outputs hold their values until the next `done`.
- R10: Cycles with `in_valid` low are ignored at every point in an instruction, including between displacement bytes.
- R11: A synchronous reset in the middle of an instruction returns the decoder to waiting for a first byte and clears the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| done | output | 1 | One-cycle completion pulse |
| unsupported | output | 1 | One-cycle pulse for a non-escape first byte |
| op_class | output | 4 | Operation code (0..7 arithmetic, 8 load, 15 raw) |
| opnd_tag | output | 2 | Operand type (0 none, 1 single, 2 double, 3 stack) |
| is_reg | output | 1 | Register form of the ModR/M byte |
| st_idx | output | 3 | Stack register index in register form, else 0 |
| ext_idx | output | 8 | Extension index (3-bit field or whole byte) |
| grp_idx | output | 3 | Escape group, first byte bits 2..0 |
| disp | output | 32 | Assembled displacement |

## Verification
Every result comes from a register loaded by the edge that accepts the final byte. `done` and the decoded fields are therefore due one cycle after the ModR/M byte, or one cycle after the fourth displacement byte. `unsupported` is due one cycle after a rejected first byte.

The bench drives bytes on falling edges and reads the outputs on the falling edge right after the accepting rising edge. It reads them again one cycle later to confirm that the pulses have dropped and the fields have held. Stalled sequences move the due cycle together with the final valid byte, and the bench checks that no completion appears earlier.

// File: rtl/fpesc_pkg.sv
package fpesc_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_MUL  = 4'd1,
      OP_COM  = 4'd2,
      OP_COMP = 4'd3,
      OP_SUB  = 4'd4,
      OP_SUBR = 4'd5,
      OP_DIV  = 4'd6,
      OP_DIVR = 4'd7,
      OP_LOAD = 4'd8,
      OP_RAW  = 4'd15
   } fp_op_e;

   typedef enum logic [1:0] {
      TAG_NONE   = 2'd0,
      TAG_SINGLE = 2'd1,
      TAG_DOUBLE = 2'd2,
      TAG_STACK  = 2'd3
   } fp_tag_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MODRM = 2'd1,
      ST_DISP  = 2'd2
   } seq_state_e;

   typedef struct packed {
      fp_op_e     op;
      fp_tag_e    tag;
      logic       is_reg;
      logic [2:0] st;
      logic [7:0] ext;
   } dec_info_t;

endpackage

// File: rtl/fpesc_classify.sv
module fpesc_classify
   import fpesc_pkg::*;
#(
   parameter logic [2:0] FULL_GRP = 3'd0,
   parameter logic [2:0] LOAD_GRP = 3'd5
) (
   input  logic [2:0] grp,
   input  logic [7:0] modrm,
   output dec_info_t  info
);

   logic       reg_form;
   logic [2:0] nnn;

   always_comb begin
      reg_form    = (modrm[7:6] == 2'b11);
      nnn         = modrm[5:3];
      info.is_reg = reg_form;
      info.ext    = reg_form ? modrm : {5'b0, nnn};
      info.st     = reg_form ? modrm[2:0] : 3'd0;
      if (grp == FULL_GRP) begin
         info.op  = fp_op_e'({1'b0, nnn});
         info.tag = reg_form ? TAG_STACK : TAG_SINGLE;
      end else if (grp == LOAD_GRP && !reg_form && nnn == 3'd0) begin
         info.op  = OP_LOAD;
         info.tag = TAG_DOUBLE;
      end else begin
         info.op  = OP_RAW;
         info.tag = TAG_NONE;
      end
   end

endmodule

// File: rtl/fpesc_disp.sv
module fpesc_disp #(
   parameter int BYTE_W     = 8,
   parameter int DISP_BYTES = 4,
   parameter bit LITTLE_END = 1'b1,
   localparam int DISP_W    = BYTE_W * DISP_BYTES,
   localparam int CNT_W     = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              load,
   input  logic [CNT_W-1:0]  idx,
   input  logic [BYTE_W-1:0] data,
   output logic [DISP_W-1:0] nxt
);

   logic [DISP_W-1:0] value;

   generate
      if (LITTLE_END) begin : g_little
         always_comb begin
            nxt = clear ? '0 : value;
            if (load) nxt[idx*BYTE_W +: BYTE_W] = data;
         end
      end else begin : g_big
         logic [CNT_W-1:0] unused_idx;
         assign unused_idx = idx;
         always_comb begin
            nxt = clear ? '0 : value;
            if (load) nxt = {value[DISP_W-BYTE_W-1:0], data};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) value <= '0;
      else     value <= nxt;
   end

   // R8
   disp_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clear && !load) |=> (value == '0));

endmodule

// File: rtl/fpesc_seq.sv
module fpesc_seq
   import fpesc_pkg::*;
#(
   parameter int         DISP_BYTES = 4,
   parameter logic [7:0] ESC_BASE   = 8'hD8,
   localparam int        CNT_W      = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             start,
   output logic             bad_first,
   output logic             take_disp,
   output logic             finish,
   output logic [CNT_W-1:0] cnt,
   output logic [2:0]       grp,
   output logic [7:0]       modrm_cur
);

   seq_state_e state;
   logic       is_esc;
   logic       take_modrm;
   logic       needs_disp;
   logic       last_disp;
   logic [7:0] modrm_q;

   always_comb begin
      is_esc     = (in_byte[7:3] == ESC_BASE[7:3]);
      start      = (state == ST_IDLE) && in_valid && is_esc;
      bad_first  = (state == ST_IDLE) && in_valid && !is_esc;
      take_modrm = (state == ST_MODRM) && in_valid;
      needs_disp = (in_byte[7:6] == 2'b00) && (in_byte[2:0] == 3'b101);
      take_disp  = (state == ST_DISP) && in_valid;
      last_disp  = take_disp && (cnt == CNT_W'(DISP_BYTES - 1));
      finish     = (take_modrm && !needs_disp) || last_disp;
      modrm_cur  = (state == ST_MODRM) ? in_byte : modrm_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         grp     <= '0;
         modrm_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               grp   <= in_byte[2:0];
               state <= ST_MODRM;
            end
            ST_MODRM: if (take_modrm) begin
               modrm_q <= in_byte;
               cnt     <= '0;
               state   <= needs_disp ? ST_DISP : ST_IDLE;
            end
            ST_DISP: if (take_disp) begin
               cnt <= cnt + 1'b1;
               if (last_disp) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1
   esc_then_modrm_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> (state == ST_MODRM));
   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!in_valid) |=> $stable(state));
   // R7
   disp_continue_chk: assert property (@(posedge clk) disable iff (rst)
      (take_disp && !last_disp) |=> (state == ST_DISP));
   // R2
   bad_stays_idle_chk: assert property (@(posedge clk) disable iff (rst)
      bad_first |=> (state == ST_IDLE));

endmodule

// File: rtl/fpu_esc_decoder.sv
module fpu_esc_decoder
   import fpesc_pkg::*;
#(
   parameter int         BYTE_W     = 8,
   parameter int         DISP_BYTES = 4,
   parameter bit         LITTLE_END = 1'b1,
   parameter logic [7:0] ESC_BASE   = 8'hD8,
   localparam int        DISP_W     = BYTE_W * DISP_BYTES,
   localparam int        CNT_W      = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              done,
   output logic              unsupported,
   output logic [3:0]        op_class,
   output logic [1:0]        opnd_tag,
   output logic              is_reg,
   output logic [2:0]        st_idx,
   output logic [7:0]        ext_idx,
   output logic [2:0]        grp_idx,
   output logic [DISP_W-1:0] disp
);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("fpu_esc_decoder: BYTE_W must be 8");
      end
      if (DISP_BYTES < 2 || DISP_BYTES > 8) begin : g_bad_disp
         $error("fpu_esc_decoder: DISP_BYTES must be 2..8");
      end
      if (ESC_BASE[2:0] != 3'd0) begin : g_bad_base
         $error("fpu_esc_decoder: ESC_BASE must be a multiple of 8");
      end
   endgenerate

   logic              start;
   logic              bad_first;
   logic              take_disp;
   logic              finish;
   logic [CNT_W-1:0]  cnt;
   logic [2:0]        grp;
   logic [7:0]        modrm_cur;
   logic [DISP_W-1:0] disp_nxt;
   dec_info_t         info;

   fpesc_seq #(.DISP_BYTES(DISP_BYTES), .ESC_BASE(ESC_BASE)) u_seq (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
      .start(start), .bad_first(bad_first), .take_disp(take_disp),
      .finish(finish), .cnt(cnt), .grp(grp), .modrm_cur(modrm_cur)
   );

   fpesc_disp #(.BYTE_W(BYTE_W), .DISP_BYTES(DISP_BYTES), .LITTLE_END(LITTLE_END)) u_disp (
      .clk(clk), .rst(rst), .clear(start), .load(take_disp),
      .idx(cnt), .data(in_byte), .nxt(disp_nxt)
   );

   fpesc_classify u_cls (
      .grp(grp), .modrm(modrm_cur), .info(info)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done        <= 1'b0;
         unsupported <= 1'b0;
         op_class    <= '0;
         opnd_tag    <= '0;
         is_reg      <= 1'b0;
         st_idx      <= '0;
         ext_idx     <= '0;
         grp_idx     <= '0;
         disp        <= '0;
      end else begin
         done        <= finish;
         unsupported <= bad_first;
         if (finish) begin
            op_class <= info.op;
            opnd_tag <= info.tag;
            is_reg   <= info.is_reg;
            st_idx   <= info.st;
            ext_idx  <= info.ext;
            grp_idx  <= grp;
            disp     <= disp_nxt;
         end
      end
   end

   // R9
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R2
   bad_no_done_chk: assert property (@(posedge clk) disable iff (rst)
      unsupported |-> !done);
   // R4
   reg_no_disp_chk: assert property (@(posedge clk) disable iff (rst)
      (done && is_reg) |-> (disp == '0));
   // R5
   load_double_chk: assert property (@(posedge clk) disable iff (rst)
      (done && op_class == OP_LOAD) |-> (opnd_tag == TAG_DOUBLE && !is_reg));
   // R9
   hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
      (!done && !$past(finish)) |-> $stable(ext_idx));

endmodule

// File: tb/sim_fpu_esc_decoder.sv
module sim_fpu_esc_decoder;

   localparam int CLK_PER = 10;
   localparam int NV      = 14;

   typedef struct packed {
      logic [7:0]  b0;
      logic [7:0]  b1;
      logic [31:0] dval;
      logic [3:0]  op;
      logic [1:0]  tag;
      logic        rg;
      logic [2:0]  st;
      logic [7:0]  ext;
   } vec_t;

   // op: 0 add .. 7 reverse divide, 8 load, 15 raw; tag: 0 none 1 single 2 double 3 stack
   localparam vec_t VECS [NV] = '{
      '{8'hD8, 8'h05, 32'h12345678, 4'd0,  2'd1, 1'b0, 3'd0, 8'h00},
      '{8'hDD, 8'h05, 32'h00000004, 4'd8,  2'd2, 1'b0, 3'd0, 8'h00},
      '{8'hD8, 8'hC1, 32'h0,        4'd0,  2'd3, 1'b1, 3'd1, 8'hC1},
      '{8'hD8, 8'hFF, 32'h0,        4'd7,  2'd3, 1'b1, 3'd7, 8'hFF},
      '{8'hD8, 8'h38, 32'h0,        4'd7,  2'd1, 1'b0, 3'd0, 8'h07},
      '{8'hD8, 8'h5E, 32'h0,        4'd3,  2'd1, 1'b0, 3'd0, 8'h03},
      '{8'hDD, 8'h18, 32'h0,        4'd15, 2'd0, 1'b0, 3'd0, 8'h03},
      '{8'hD9, 8'hE8, 32'h0,        4'd15, 2'd0, 1'b1, 3'd0, 8'hE8},
      '{8'hDF, 8'h95, 32'h0,        4'd15, 2'd0, 1'b0, 3'd0, 8'h02},
      '{8'hD8, 8'hA0, 32'h0,        4'd4,  2'd1, 1'b0, 3'd0, 8'h04},
      '{8'hD8, 8'hEA, 32'h0,        4'd5,  2'd3, 1'b1, 3'd2, 8'hEA},
      '{8'hDD, 8'hC0, 32'h0,        4'd15, 2'd0, 1'b1, 3'd0, 8'hC0},
      '{8'hD8, 8'hBF, 32'h0,        4'd7,  2'd1, 1'b0, 3'd0, 8'h07},
      '{8'hD8, 8'hC8, 32'h0,        4'd1,  2'd3, 1'b1, 3'd0, 8'hC8}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        done, unsupported, is_reg;
   logic [3:0]  op_class;
   logic [1:0]  opnd_tag;
   logic [2:0]  st_idx, grp_idx;
   logic [7:0]  ext_idx;
   logic [31:0] disp;

   int checks = 0;
   int failures = 0;

   always #(CLK_PER/2) clk = ~clk;

   fpu_esc_decoder u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
      .done(done), .unsupported(unsupported), .op_class(op_class),
      .opnd_tag(opnd_tag), .is_reg(is_reg), .st_idx(st_idx),
      .ext_idx(ext_idx), .grp_idx(grp_idx), .disp(disp)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Drive one byte for exactly one accepting edge; return at the following falling edge.
   task automatic put(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_vec(input vec_t v);
      in_valid = 1'b1; in_byte = v.b0; @(negedge clk);
      if (v.b1[7:6] == 2'b00 && v.b1[2:0] == 3'b101) begin
         in_byte = v.b1; @(negedge clk);
         for (int k = 0; k < 3; k++) begin
            in_byte = v.dval[k*8 +: 8]; @(negedge clk);
         end
         put(v.dval[31:24]);
      end else begin
         put(v.b1);
      end
   endtask

   initial begin
      #(CLK_PER * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      rst = 1'b0;
      // R1 reset state
      chk("R1", "reset done", {31'b0, done}, 0);
      chk("R1", "reset unsupported", {31'b0, unsupported}, 0);
      chk("R1", "reset ext", {24'b0, ext_idx}, 0);
      chk("R1", "reset disp", disp, 0);

      // table walk: R3 R4 R5 R6 R7 R8
      for (int n = 0; n < NV; n++) begin
         send_vec(VECS[n]);
         chk("R9", $sformatf("v%0d done", n), {31'b0, done}, 1);
         chk("R3", $sformatf("v%0d op", n), {28'b0, op_class}, {28'b0, VECS[n].op});
         chk("R6", $sformatf("v%0d tag", n), {30'b0, opnd_tag}, {30'b0, VECS[n].tag});
         chk("R4", $sformatf("v%0d is_reg", n), {31'b0, is_reg}, {31'b0, VECS[n].rg});
         chk("R4", $sformatf("v%0d st", n), {29'b0, st_idx}, {29'b0, VECS[n].st});
         chk("R5", $sformatf("v%0d ext", n), {24'b0, ext_idx}, {24'b0, VECS[n].ext});
         chk("R1", $sformatf("v%0d grp", n), {29'b0, grp_idx}, {29'b0, VECS[n].b0[2:0]});
         chk("R7", $sformatf("v%0d disp", n), disp, VECS[n].dval);
         @(negedge clk);
         chk("R9", $sformatf("v%0d done drop", n), {31'b0, done}, 0);
      end

      // R9 hold after completion (last vector D8 C8)
      idle(3);
      chk("R9", "hold op", {28'b0, op_class}, 1);
      chk("R9", "hold ext", {24'b0, ext_idx}, 32'hC8);
      chk("R9", "hold done low", {31'b0, done}, 0);

      // R2 non-escape first bytes
      put(8'h90);
      chk("R2", "unsup 90", {31'b0, unsupported}, 1);
      chk("R2", "no done 90", {31'b0, done}, 0);
      @(negedge clk);
      chk("R2", "unsup drop", {31'b0, unsupported}, 0);
      put(8'hD7);
      chk("R2", "unsup D7", {31'b0, unsupported}, 1);
      idle(1);
      put(8'hE0);
      chk("R2", "unsup E0", {31'b0, unsupported}, 1);
      idle(1);
      put(8'hDA); put(8'hD1);
      chk("R2", "idle after reject done", {31'b0, done}, 1);
      chk("R2", "idle after reject ext", {24'b0, ext_idx}, 32'hD1);
      chk("R2", "idle after reject grp", {29'b0, grp_idx}, 2);

      // R10 stalls inside an instruction
      idle(1);
      put(8'hD8); idle(2);
      chk("R10", "no done after first", {31'b0, done}, 0);
      put(8'h05);
      chk("R10", "no done before disp", {31'b0, done}, 0);
      put(8'h78); idle(1);
      put(8'h56);
      put(8'h34); idle(3);
      chk("R10", "no done mid disp", {31'b0, done}, 0);
      put(8'h12);
      chk("R10", "stalled done", {31'b0, done}, 1);
      chk("R10", "stalled disp", disp, 32'h12345678);
      chk("R10", "stalled op", {28'b0, op_class}, 0);

      // R11 reset in the middle of an instruction
      idle(1);
      put(8'hD8);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R11", "reset clears ext", {24'b0, ext_idx}, 0);
      chk("R11", "reset clears disp", disp, 0);
      put(8'hC1);
      chk("R11", "byte after reset is first byte", {31'b0, unsupported}, 1);
      chk("R11", "no done after reset", {31'b0, done}, 0);

      // R8 non-displacement memory form after a displacement one
      idle(1);
      put(8'hD8); put(8'h45);
      chk("R8", "mod01 disp zero", disp, 0);
      chk("R8", "mod01 op", {28'b0, op_class}, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule